// File: doc/BRIEF.md
# Mesh Clock Domain Delay Tap Controller

Each clock domain of a deskew mesh carries one copy of this controller. Phase comparators sit on the borders between adjacent domains. Each of them asks the domains on either side for more or less clock delay. This controller takes those requests from up to four sides, masks the sides that have no comparator, and combines what is left into one move decision. It holds the resulting delay setting as a thermometer code, which drives the tap select of a tunable delay buffer.

Requests count only when the update strobe is high for a cycle. Between strobes the setting stays frozen, so the comparators have time to settle after each change. An increase request on any enabled side grows the code by one tap, and a decrease request on any enabled side shrinks it by one tap. When both kinds are seen in the same update, the setting stays where it is. At either end of the range the code saturates and a sticky limit flag is set. The tap count is also given in binary. No instance depends on any other instance; each one acts only on its own inputs.

Top module: `mesh_tap_ctrl`

## Requirements
- R1: While rst_n is low, the setting goes to the mid-scale code: the lower TAPS/2 bits of tap_therm are 1 and the rest are 0. With the defaults this is 16'h00FF, tap_idx = 8, at_limit = 0.
- R2: When upd_stb is low at a clock edge, tap_therm and tap_idx do not change, whatever the request inputs do.
- R3: At a strobed edge, if some enabled side raises add_req and no enabled side raises sub_req, and the code is not all ones, the code gains one 1 at its low end: tap_therm becomes {tap_therm[TAPS-2:0],1}, and tap_idx increases by 1.
- R4: At a strobed edge, if some enabled side raises sub_req and no enabled side raises add_req, and the code is not zero, the code loses its top 1: tap_therm becomes {0,tap_therm[TAPS-1:1]}, and tap_idx decreases by 1.
- R5: At a strobed edge where the enabled sides raise both add_req and sub_req, the setting does not change.
- R6: A side whose dir_en bit is 0 has no effect. Bit 0 is north, bit 1 east, bit 2 south and bit 3 west, and the same order is used for add_req and sub_req.
- R7: An increase request while tap_therm is all ones leaves the code unchanged and sets at_limit.
- R8: A decrease request while tap_therm is all zeros leaves the code unchanged and sets at_limit.
- R9: Once at_limit is set, it stays set until reset.
- R10: tap_idx always equals the number of 1 bits in tap_therm, and tap_therm always has the form 0…01…1.
- R11: One enabled side is enough to cause a move; the requests of the same kind from all enabled sides are ORed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset to mid-scale |
| upd_stb | input | 1 | One-cycle strobe that samples the requests |
| dir_en | input | NDIR (4) | Per-side enable; bit order N, E, S, W |
| add_req | input | NDIR (4) | Per-side request to add delay |
| sub_req | input | NDIR (4) | Per-side request to remove delay |
| tap_therm | output | TAPS (16) | Thermometer-coded delay setting |
| tap_idx | output | IDXW (5) | Number of taps set, in binary |
| at_limit | output | 1 | Sticky flag for a request blocked at an end of the range |

## Verification
The assertions assume that dir_en, add_req, sub_req and upd_stb are synchronous to clk and free of X once reset is released. They also assume that reset is the only way the setting is forced. The bench changes every input on the falling clock edge, so each rising edge sees stable values. It mixes random strobes, enables and requests with directed runs. The directed runs drive the setting into both ends of the range, then send conflicting requests and requests from masked sides.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
   localparam int NDIR = 4;

   // side order shared by dir_en, add_req and sub_req
   typedef enum logic [1:0] {
      SIDE_N = 2'd0,
      SIDE_E = 2'd1,
      SIDE_S = 2'd2,
      SIDE_W = 2'd3
   } mtc_side_e;

   typedef struct packed {
      logic grow;
      logic shrink;
   } mtc_cmd_t;
endpackage

// File: rtl/mtc_req_merge.sv
module mtc_req_merge
   import mtc_pkg::*;
#(
   parameter int N_SIDES = NDIR
) (
   input  logic [N_SIDES-1:0] side_en,
   input  logic [N_SIDES-1:0] side_add,
   input  logic [N_SIDES-1:0] side_sub,
   output mtc_cmd_t           cmd
);
   logic [N_SIDES-1:0] add_m;
   logic [N_SIDES-1:0] sub_m;

   generate
      if (N_SIDES < 1 || N_SIDES > 4) begin : g_bad_sides
         $error("mtc_req_merge: N_SIDES must be 1..4");
      end
      for (genvar s = 0; s < N_SIDES; s++) begin : g_side
         assign add_m[s] = side_en[s] & side_add[s];
         assign sub_m[s] = side_en[s] & side_sub[s];
      end
   endgenerate

   assign cmd.grow   = |add_m;
   assign cmd.shrink = |sub_m;
endmodule

// File: rtl/mtc_thermo_reg.sv
module mtc_thermo_reg
   import mtc_pkg::*;
#(
   parameter int TAPS       = 16,
   parameter int RESET_TAPS = TAPS / 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stb,
   input  mtc_cmd_t        cmd,
   output logic [TAPS-1:0] therm,
   output logic            lim
);
   localparam logic [TAPS-1:0] ONE_V   = {{(TAPS-1){1'b0}}, 1'b1};
   localparam logic [TAPS-1:0] RST_VEC = (ONE_V << RESET_TAPS) - ONE_V;

   generate
      if (TAPS < 2) begin : g_bad_taps
         $error("mtc_thermo_reg: TAPS must be at least 2");
      end
      if (RESET_TAPS < 0 || RESET_TAPS > TAPS) begin : g_bad_rst
         $error("mtc_thermo_reg: RESET_TAPS out of range");
      end
   endgenerate

   logic full, empty;
   assign full  = &therm;
   assign empty = ~|therm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         therm <= RST_VEC;
         lim   <= 1'b0;
      end else if (stb) begin
         if (cmd.grow && !cmd.shrink) begin
            if (full) lim <= 1'b1;
            else      therm <= {therm[TAPS-2:0], 1'b1};
         end else if (cmd.shrink && !cmd.grow) begin
            if (empty) lim <= 1'b1;
            else       therm <= {1'b0, therm[TAPS-1:1]};
         end
      end
   end

   AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n) !stb |=> $stable(therm)); // R2
   AST_CONFLICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (stb && cmd.grow && cmd.shrink) |=> $stable(therm)); // R5
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ($countones(therm ^ $past(therm)) <= 1)); // R3
   AST_THERMO_FORM: assert property (@(posedge clk) disable iff (!rst_n) ((therm + ONE_V) & therm) == '0); // R10
   AST_LIMIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) lim |=> lim); // R9
endmodule

// File: rtl/mtc_tap_count.sv
module mtc_tap_count #(
   parameter int TAPS = 16,
   parameter int IDXW = $clog2(TAPS + 1)
) (
   input  logic [TAPS-1:0] therm,
   output logic [IDXW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < TAPS; i++) idx = idx + IDXW'(therm[i]);
   end
endmodule

// File: rtl/mesh_tap_ctrl.sv
module mesh_tap_ctrl
   import mtc_pkg::*;
#(
   parameter int TAPS       = 16,
   parameter int RESET_TAPS = TAPS / 2,
   parameter int IDXW       = $clog2(TAPS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_stb,
   input  logic [NDIR-1:0]  dir_en,
   input  logic [NDIR-1:0]  add_req,
   input  logic [NDIR-1:0]  sub_req,
   output logic [TAPS-1:0]  tap_therm,
   output logic [IDXW-1:0]  tap_idx,
   output logic             at_limit
);
   generate
      if (IDXW < $clog2(TAPS + 1)) begin : g_bad_idxw
         $error("mesh_tap_ctrl: IDXW too narrow for TAPS");
      end
   endgenerate

   mtc_cmd_t cmd;

   mtc_req_merge #(.N_SIDES(NDIR)) u_merge (
      .side_en (dir_en),
      .side_add(add_req),
      .side_sub(sub_req),
      .cmd     (cmd)
   );

   mtc_thermo_reg #(.TAPS(TAPS), .RESET_TAPS(RESET_TAPS)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .stb  (upd_stb),
      .cmd  (cmd),
      .therm(tap_therm),
      .lim  (at_limit)
   );

   mtc_tap_count #(.TAPS(TAPS), .IDXW(IDXW)) u_cnt (
      .therm(tap_therm),
      .idx  (tap_idx)
   );

   AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $countones(tap_therm) == int'(tap_idx)); // R10
   AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (upd_stb && ((dir_en & (add_req | sub_req)) == '0)) |=> $stable(tap_therm)); // R6
   AST_TOP_SAT: assert property (@(posedge clk) disable iff (!rst_n) (upd_stb && (&tap_therm) && |(dir_en & add_req) && !(|(dir_en & sub_req))) |=> (at_limit && $stable(tap_therm))); // R7
   AST_BOT_SAT: assert property (@(posedge clk) disable iff (!rst_n) (upd_stb && (tap_therm == '0) && |(dir_en & sub_req) && !(|(dir_en & add_req))) |=> (at_limit && $stable(tap_therm))); // R8
endmodule

// File: tb/mesh_tap_ctrl_bench.sv
module mesh_tap_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int TAPS = 16;
   localparam int IDXW = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            upd_stb = 1'b0;
   logic [3:0]      dir_en = '0, add_req = '0, sub_req = '0;
   logic [TAPS-1:0] tap_therm;
   logic [IDXW-1:0] tap_idx;
   logic            at_limit;

   int n_tests = 0, n_fail = 0;
   int m_idx = 8;
   bit m_lim = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mesh_tap_ctrl u_mesh_tap_ctrl (
      .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .dir_en(dir_en),
      .add_req(add_req), .sub_req(sub_req),
      .tap_therm(tap_therm), .tap_idx(tap_idx), .at_limit(at_limit)
   );

   function automatic logic [TAPS-1:0] exp_therm(int k);
      logic [TAPS-1:0] v = '0;
      for (int i = 0; i < TAPS; i++) if (i < k) v[i] = 1'b1;
      return v;
   endfunction

   // reference model of one strobed update (R3..R8, R11)
   function automatic void model_step(logic stb, logic [3:0] en, logic [3:0] a, logic [3:0] s);
      bit g = |(en & a);
      bit h = |(en & s);
      if (!stb) return;
      if (g && !h) begin
         if (m_idx == TAPS) m_lim = 1; else m_idx++;
      end else if (h && !g) begin
         if (m_idx == 0) m_lim = 1; else m_idx--;
      end
   endfunction

   task automatic check(string req);
      n_tests++;
      if (tap_therm !== exp_therm(m_idx) || tap_idx !== IDXW'(m_idx) || at_limit !== m_lim) begin
         n_fail++;
         $display("FAIL %s: therm=%h idx=%0d lim=%b expected therm=%h idx=%0d lim=%b",
                  req, tap_therm, tap_idx, at_limit, exp_therm(m_idx), m_idx, m_lim);
      end
   endtask

   task automatic step(logic stb, logic [3:0] en, logic [3:0] a, logic [3:0] s);
      upd_stb = stb; dir_en = en; add_req = a; sub_req = s;
      model_step(stb, en, a, s);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      upd_stb = 0; dir_en = '0; add_req = '0; sub_req = '0;
      @(negedge clk); @(negedge clk);
      m_idx = TAPS / 2; m_lim = 0;
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog: expired, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_1234);
      @(negedge clk);
      do_reset();
      check("R1");
      // R2: requests without strobe do nothing
      step(0, 4'hF, 4'hF, 4'h0); check("R2");
      step(0, 4'hF, 4'h0, 4'hF); check("R2");
      // R3/R11: each side alone grows the code
      for (int d = 0; d < 4; d++) begin
         step(1, 4'hF, 4'(1 << d), 4'h0); check("R3 R11");
      end
      // R4: shrink
      step(1, 4'b0101, 4'h0, 4'b0100); check("R4");
      // R5: conflict from different sides holds
      step(1, 4'hF, 4'b0001, 4'b1000); check("R5");
      // R6: masked sides ignored
      step(1, 4'b0011, 4'b1100, 4'b0000); check("R6");
      step(1, 4'b0011, 4'b0001, 4'b0100); check("R6");
      step(1, 4'b0000, 4'hF, 4'hF); check("R6");
      // R7: drive to top and beyond
      for (int k = 0; k < 12; k++) step(1, 4'b1000, 4'b1000, 4'h0);
      check("R7");
      step(1, 4'b1000, 4'b1000, 4'h0); check("R7");
      // R9: moving away keeps the flag
      step(1, 4'h1, 4'h0, 4'h1); check("R9");
      do_reset();
      // R8: drive to bottom and beyond
      for (int k = 0; k < 9; k++) step(1, 4'h2, 4'h0, 4'h2);
      check("R8");
      step(1, 4'h2, 4'h0, 4'h2); check("R8");
      step(1, 4'h4, 4'h4, 4'h0); check("R9");
      do_reset();
      // random mix, checked every cycle (R10 with model)
      for (int k = 0; k < 3000; k++) begin
         step(1'($urandom_range(0, 1)), 4'($urandom), 4'($urandom), 4'($urandom & $urandom));
         check("R10");
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule